// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a watchdog with a three-register memory-mapped interface: control/status, counter/command and timeout value. It counts ticks of a slow time base, which enters as a one-cycle enable pulse on the system clock. An optional divider lets the count advance once every 256 ticks instead of on every tick. When the count reaches the programmed timeout, the block sets a sticky flag and raises a reset request. If the interrupt is enabled, it raises the interrupt first and issues the reset request a fixed number of clocks later.

Configuration is protected. The control and timeout registers accept writes only inside a short window that opens after a key is written to the counter/command register. Software keeps the watchdog alive by writing a separate refresh key to the same register. Keys arrive as two 16-bit halves in consecutive writes or, once the 32-bit command mode is selected, as one 32-bit word. Two status bits report whether the window is open and whether the last accepted configuration has taken effect.

Top module: `wdk_top`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control/status), 0x4 (counter/command) and 0x8 (timeout); any other address reads 0 and writes to it do nothing. Read data appears one cycle after `rd_en`. After reset, control/status reads 0x0000_0020, timeout reads `TO_RST`, count reads 0, and `irq` and `rst_req` are low.
- R2: With control bit 13 clear, writing 0xC520 and then 0xD928 as the low halves of two consecutive counter-register writes sets status bit 11 (unlocked). This happens only while bit 5 (update-allowed) is set.
- R3: With control bit 13 set, a single counter-register write of 0xD928C520 sets bit 11. In this mode the two 16-bit halves written separately do not unlock.
- R4: In 16-bit mode, a wrong value after the first key half cancels the sequence, and the block stays locked.
- R5: A write to the control bits or to the timeout register takes effect only while bit 11 and bit 5 are both set. Otherwise the register keeps its value.
- R6: The unlocked status clears by itself `UNLOCK_WIN` clocks after the unlock.
- R7: Status bit 10 clears when an unlock completes and sets when a configuration write is accepted. Accepted values read back exactly as written in bits 13:12, 9:5 and 1:0.
- R8: A refresh key clears the count: 0xB480A602 as one write in 32-bit mode, or 0xA602 then 0xB480 as two consecutive writes in 16-bit mode.
- R9: While bit 7 (enable) is set, the count rises by one per tick. While bit 7 is clear it holds. It reads at offset 0x4.
- R10: With bit 12 (prescaler) set, the count rises once per 256 ticks.
- R11: With enable set, the count stops at the timeout value and status bit 14 (timeout flag) sets. Writing 1 to bit 14 clears it unless the timeout condition still holds.
- R12: At the timeout event, `rst_req` rises in the same cycle as the flag if bit 6 (interrupt enable) is clear. If bit 6 is set, `irq` rises with the flag and `rst_req` follows exactly `IRQ_DELAY` clocks later. `rst_req` stays high until reset.
- R13: An accepted configuration write clears the count and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse of the slow time base |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Timeout interrupt |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The hardest state to reach is a timeout with the interrupt enabled. To get there, the stimulus has to:
- complete a 16-bit unlock;
- program a small timeout and then enable, interrupt enable and 32-bit mode inside the same window;
- run ticks until `irq` rises.

The bench then counts clocks to the reset request. Clearing the sticky flag is just as indirect. The count must first be disabled through a fresh 32-bit unlock, because the flag re-sets for as long as the timeout condition holds, and only then is the flag written with a one.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [15:0] KEY_UNL_LO = 16'hC520;
  localparam logic [15:0] KEY_UNL_HI = 16'hD928;
  localparam logic [15:0] KEY_REF_LO = 16'hA602;
  localparam logic [15:0] KEY_REF_HI = 16'hB480;
  localparam logic [31:0] KEY_UNL_32 = {KEY_UNL_HI, KEY_UNL_LO};
  localparam logic [31:0] KEY_REF_32 = {KEY_REF_HI, KEY_REF_LO};

  localparam int OFF_CS  = 0;
  localparam int OFF_CMD = 4;
  localparam int OFF_TO  = 8;

  // control/status bit positions
  localparam int B_FLAG  = 14;
  localparam int B_CMD32 = 13;
  localparam int B_PRES  = 12;
  localparam int B_ULK   = 11;
  localparam int B_RCS   = 10;
  localparam int B_CLKH  = 9;
  localparam int B_CLKL  = 8;
  localparam int B_EN    = 7;
  localparam int B_IE    = 6;
  localparam int B_UPD   = 5;
  localparam int B_WAIT  = 1;
  localparam int B_STOP  = 0;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_UNL, SEQ_REF} seq_e;

  typedef struct packed {
    logic       cmd32;
    logic       pres;
    logic [1:0] clksel;
    logic       en;
    logic       ie;
    logic       upd;
    logic       run_wait;
    logic       run_stop;
  } cfg_t;
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] wdata,
  input  logic        mode32,
  input  logic        upd_ok,
  output logic        unlock_p,
  output logic        refresh_p
);
  seq_e seq_q, seq_d;
  logic [15:0] lo;

  assign lo = wdata[15:0];

  always_comb begin
    unlock_p  = 1'b0;
    refresh_p = 1'b0;
    seq_d     = seq_q;
    if (cmd_wr) begin
      if (mode32) begin
        unlock_p  = (wdata == KEY_UNL_32) && upd_ok;
        refresh_p = (wdata == KEY_REF_32);
        seq_d     = SEQ_IDLE;
      end else if (seq_q == SEQ_UNL && lo == KEY_UNL_HI) begin
        unlock_p = upd_ok;
        seq_d    = SEQ_IDLE;
      end else if (seq_q == SEQ_REF && lo == KEY_REF_HI) begin
        refresh_p = 1'b1;
        seq_d     = SEQ_IDLE;
      end else if (lo == KEY_UNL_LO) begin
        seq_d = SEQ_UNL;
      end else if (lo == KEY_REF_LO) begin
        seq_d = SEQ_REF;
      end else begin
        seq_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seq_q <= SEQ_IDLE;
    else     seq_q <= seq_d;
  end
endmodule

// File: rtl/wdk_window.sv
module wdk_window #(
  parameter int UNLOCK_WIN = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic open_p,
  output logic is_open
);
  localparam int WIN_W = $clog2(UNLOCK_WIN + 1);
  logic [WIN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                 left_q <= '0;
    else if (open_p)         left_q <= WIN_W'(UNLOCK_WIN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign is_open = (left_q != '0);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             pres,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_wrap, step;

  assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));
  assign step     = tick && (!pres || pre_wrap);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      if (tick && pres) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (step && cnt_q < limit) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign hit = en && (cnt_q >= limit);
endmodule

// File: rtl/wdk_alarm.sv
module wdk_alarm #(
  parameter int IRQ_DELAY = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic ie,
  output logic rst_req
);
  localparam int DLY_W = $clog2(IRQ_DELAY + 1);
  logic             armed_q, wait_q, req_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      wait_q  <= 1'b0;
      req_q   <= 1'b0;
      dly_q   <= '0;
    end else begin
      if (!armed_q && hit) begin
        armed_q <= 1'b1;
        if (ie) begin
          wait_q <= 1'b1;
          dly_q  <= '0;
        end else begin
          req_q <= 1'b1;
        end
      end
      if (wait_q) begin
        if (dly_q == DLY_W'(IRQ_DELAY - 1)) begin
          req_q  <= 1'b1;
          wait_q <= 1'b0;
        end else begin
          dly_q <= dly_q + 1'b1;
        end
      end
    end
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 16,
  parameter int TO_RST     = 1024,
  parameter int UNLOCK_WIN = 256,
  parameter int IRQ_DELAY  = 128,
  parameter int PRE_DIV    = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              rst_req
);
  cfg_t             cfg_q, cfg_wr;
  logic [CNT_W-1:0] toval_q, cnt_w;
  logic             flag_q, flag_d, rcs_q, irq_q, ie_d;
  logic [31:0]      rdata_q, cs_view;
  logic             hit_w, unl_p, ref_p, ulk_w;
  logic             wr_cs, wr_cmd, wr_to, acc_cs, acc_to, acc_any;

  assign wr_cs   = wr_en && (addr == ADDR_W'(OFF_CS));
  assign wr_cmd  = wr_en && (addr == ADDR_W'(OFF_CMD));
  assign wr_to   = wr_en && (addr == ADDR_W'(OFF_TO));
  assign acc_cs  = wr_cs && ulk_w && cfg_q.upd;
  assign acc_to  = wr_to && ulk_w && cfg_q.upd;
  assign acc_any = acc_cs || acc_to;

  always_comb begin
    cfg_wr.cmd32    = wdata[B_CMD32];
    cfg_wr.pres     = wdata[B_PRES];
    cfg_wr.clksel   = wdata[B_CLKH:B_CLKL];
    cfg_wr.en       = wdata[B_EN];
    cfg_wr.ie       = wdata[B_IE];
    cfg_wr.upd      = wdata[B_UPD];
    cfg_wr.run_wait = wdata[B_WAIT];
    cfg_wr.run_stop = wdata[B_STOP];
  end

  wdk_keyseq u_keys (
    .clk(clk), .rst(rst), .cmd_wr(wr_cmd), .wdata(wdata),
    .mode32(cfg_q.cmd32), .upd_ok(cfg_q.upd),
    .unlock_p(unl_p), .refresh_p(ref_p)
  );

  wdk_window #(.UNLOCK_WIN(UNLOCK_WIN)) u_win (
    .clk(clk), .rst(rst), .open_p(unl_p), .is_open(ulk_w)
  );

  wdk_counter #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .en(cfg_q.en), .pres(cfg_q.pres),
    .clear(ref_p || acc_any), .limit(toval_q), .cnt(cnt_w), .hit(hit_w)
  );

  wdk_alarm #(.IRQ_DELAY(IRQ_DELAY)) u_alarm (
    .clk(clk), .rst(rst), .hit(hit_w), .ie(cfg_q.ie), .rst_req(rst_req)
  );

  // flag: set by the timeout condition, write-one-to-clear otherwise
  always_comb begin
    if (hit_w)                     flag_d = 1'b1;
    else if (wr_cs && wdata[B_FLAG]) flag_d = 1'b0;
    else                           flag_d = flag_q;
  end
  assign ie_d = acc_cs ? cfg_wr.ie : cfg_q.ie;

  always_comb begin
    cs_view          = '0;
    cs_view[B_FLAG]  = flag_q;
    cs_view[B_CMD32] = cfg_q.cmd32;
    cs_view[B_PRES]  = cfg_q.pres;
    cs_view[B_ULK]   = ulk_w;
    cs_view[B_RCS]   = rcs_q;
    cs_view[B_CLKH:B_CLKL] = cfg_q.clksel;
    cs_view[B_EN]    = cfg_q.en;
    cs_view[B_IE]    = cfg_q.ie;
    cs_view[B_UPD]   = cfg_q.upd;
    cs_view[B_WAIT]  = cfg_q.run_wait;
    cs_view[B_STOP]  = cfg_q.run_stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cfg_q.upd <= 1'b1;
      toval_q   <= CNT_W'(TO_RST);
      flag_q    <= 1'b0;
      rcs_q     <= 1'b0;
      irq_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (acc_cs) cfg_q   <= cfg_wr;
      if (acc_to) toval_q <= wdata[CNT_W-1:0];
      if (unl_p)        rcs_q <= 1'b0;
      else if (acc_any) rcs_q <= 1'b1;
      flag_q <= flag_d;
      irq_q  <= flag_d && ie_d;
      if (rd_en) begin
        if (addr == ADDR_W'(OFF_CS))       rdata_q <= cs_view;
        else if (addr == ADDR_W'(OFF_CMD)) rdata_q <= 32'(cnt_w);
        else if (addr == ADDR_W'(OFF_TO))  rdata_q <= 32'(toval_q);
        else                               rdata_q <= '0;
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             to_sel,
  input logic             ulk,
  input logic             upd,
  input logic             en,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] toval,
  input logic             irq,
  input logic             rst_req
);
  p_locked_to_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && to_sel && !ulk) |=> $stable(toval));

  p_unlock_upd_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ulk) |-> upd);

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_en) |=> $stable(cnt));

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= toval);

  p_irq_flag_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> flag);

  p_rst_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);
endmodule

bind wdk_top wdk_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .to_sel(wr_to), .ulk(ulk_w),
  .upd(cfg_q.upd), .en(cfg_q.en), .flag(flag_q), .cnt(cnt_w),
  .toval(toval_q), .irq(irq), .rst_req(rst_req)
);

// File: tb/tb_wdk_top.sv
module tb_wdk_top;
  localparam int TO_RST    = 1024;
  localparam int IRQ_DELAY = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wdk_top dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  // scoreboard monitor: compares read data one cycle after each read strobe
  initial begin
    bit arm;
    forever begin
      @(posedge clk);
      arm = rd_en;
      @(negedge clk);
      if (arm && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic unlock16();
    wr(4'h4, 32'h0000_C520);
    wr(4'h4, 32'h0000_D928);
  endtask

  initial begin
    int k;
    do_reset();
    // R1 reset state
    rd(4'h0, 32'h0000_0020, "R1 cs reset");
    rd(4'h8, 32'(TO_RST), "R1 timeout reset");
    rd(4'h4, 32'h0, "R1 count reset");
    rd(4'hC, 32'h0, "R1 unmapped address");
    @(negedge clk);
    chk(irq, 1'b0, "R1 irq reset");
    chk(rst_req, 1'b0, "R1 rst_req reset");

    // R5 locked write ignored
    wr(4'h8, 32'd5);
    rd(4'h8, 32'(TO_RST), "R5 locked timeout write");

    // R2 16-bit unlock, R7 readback
    unlock16();
    rd(4'h0, 32'h0000_0820, "R2 unlocked status");
    wr(4'h8, 32'd5);
    rd(4'h8, 32'd5, "R7 timeout readback");
    rd(4'h0, 32'h0000_0C20, "R7 complete status");
    ticks(10);
    rd(4'h4, 32'h0, "R9 count holds while disabled");
    wr(4'h0, 32'h0000_20A0);
    rd(4'h0, 32'h0000_2CA0, "R7 cs readback while open");
    repeat (300) @(negedge clk);
    rd(4'h0, 32'h0000_24A0, "R6 window closed");

    // R3 32-bit mode: halves do not unlock, full word does
    wr(4'h4, 32'h0000_C520);
    wr(4'h4, 32'h0000_D928);
    rd(4'h0, 32'h0000_24A0, "R3 halves ignored in 32-bit mode");
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, 32'h0000_28A0, "R3 32-bit unlock, R7 complete cleared");

    // R9 counting, R8 32-bit refresh
    ticks(3);
    rd(4'h4, 32'd3, "R9 count three ticks");
    wr(4'h4, 32'hB480_A602);
    rd(4'h4, 32'h0, "R8 32-bit refresh");
    ticks(10);
    @(negedge clk);
    chk(rst_req, 1'b1, "R12 immediate reset without irq enable");
    chk(irq, 1'b0, "R12 irq stays low when disabled");
    rd(4'h4, 32'd5, "R11 count stops at timeout");
    rd(4'h0, 32'h0000_68A0, "R11 flag set");

    // R11 flag clear, R13 count cleared by config write
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_2020);
    wr(4'h0, 32'h0000_6020);
    rd(4'h0, 32'h0000_2C20, "R11 flag cleared by write one");
    rd(4'h4, 32'h0, "R13 config write clears count");
    @(negedge clk);
    chk(rst_req, 1'b1, "R12 rst_req sticky");

    // R4 wrong key cancels, then R12 irq path
    do_reset();
    wr(4'h4, 32'h0000_C520);
    wr(4'h4, 32'h0000_1234);
    wr(4'h4, 32'h0000_D928);
    rd(4'h0, 32'h0000_0020, "R4 wrong key keeps locked");
    unlock16();
    wr(4'h8, 32'd3);
    wr(4'h0, 32'h0000_20E0);
    @(negedge clk);
    tick = 1'b1;
    k = 0;
    while (!irq && k < 50) begin
      @(negedge clk);
      k++;
    end
    tick = 1'b0;
    chk(irq, 1'b1, "R12 irq raised at timeout");
    chk(rst_req, 1'b0, "R12 reset delayed after irq");
    k = 0;
    while (!rst_req && k < 1000) begin
      @(negedge clk);
      k++;
    end
    n_run++;
    if (k != IRQ_DELAY) begin
      n_fail++;
      $display("FAIL R12 irq to reset delay: got %0d expected %0d", k, IRQ_DELAY);
    end

    // R5 update-allowed clear blocks writes
    do_reset();
    unlock16();
    wr(4'h0, 32'h0000_2000);
    rd(4'h0, 32'h0000_2C00, "R7 update bit cleared readback");
    wr(4'h8, 32'd7);
    rd(4'h8, 32'(TO_RST), "R5 write ignored with update clear");

    // R10 prescaler, R8 16-bit refresh
    do_reset();
    unlock16();
    wr(4'h8, 32'd2);
    wr(4'h0, 32'h0000_10A0);
    ticks(300);
    rd(4'h4, 32'd1, "R10 one step per 256 ticks");
    @(negedge clk);
    chk(rst_req, 1'b0, "R10 no timeout yet");
    wr(4'h4, 32'h0000_A602);
    wr(4'h4, 32'h0000_B480);
    rd(4'h4, 32'h0, "R8 16-bit refresh");
    ticks(600);
    rd(4'h4, 32'd2, "R10 reached timeout");
    @(negedge clk);
    chk(rst_req, 1'b1, "R10 timeout with prescaler");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule